// File: doc/BRIEF.md
# Status Ring Overflow Guard

This block is the producer side of a set of status rings that live in host memory. Two producers post status entries into these rings: a segmentation engine and a reassembly engine. Each request carries a ring number. For every ring the block keeps a write index, and it also keeps a shadow of the most recent read index that the host has reported. When a request is granted, the block issues one memory write on the following cycle. The address of that write is the ring's base plus the write index scaled by the entry size.

Before each entry is posted, the block checks whether this write would take the last free slot. A write takes the last free slot when the write index plus one, modulo the depth, equals the read shadow. In that case the entry is written with its overflow bit set, the write index is held, and the ring is marked stalled. Requests aimed at a stalled ring are refused. Requests for every other ring keep flowing.

The host reports progress by writing a new read index for a ring. If that new value frees at least one slot on a stalled ring, the stall clears and the write index steps past the overflow entry. The ring then runs normally again.

Top module: `status_ring_guard`

## Requirements
- R1: After reset, all write indices and read shadows are 0, no ring is stalled, `memWe` and `memOvfl` are low and no acknowledge is given.
- R2: A segmentation request on a non-stalled ring is acknowledged in the same cycle. A reassembly request is acknowledged only when its ring is not stalled and no segmentation request is acknowledged that cycle. A refused request stays asserted by its producer until it is acknowledged, and it is then accepted.
- R3: One cycle after an acknowledge, `memWe` is high for exactly one cycle. `memAddr` = `BASE_ORIGIN + ring*BASE_STRIDE + index*ENTRY_BYTES`. With default parameters this is 0x10000 + ring*0x1000 + index*8. No write occurs in a cycle that follows no acknowledge.
- R4: `memData[DATA_W-1:0]` carries the granted producer's payload. `memData[DATA_W]` (the most significant bit) is the overflow indicator.
- R5: A granted write whose index plus one (mod `DEPTH`) equals the ring's read shadow is written with bit `DATA_W` set and with `memOvfl` high. The ring's write index does not advance, and `ringStall` for that ring rises in the same cycle as the write.
- R6: A granted write that is not an overflow advances that ring's write index by one, wrapping from `DEPTH-1` to 0.
- R7: While a ring is stalled, no request for it is acknowledged and no entry is written to it. Requests for other rings are acknowledged and written exactly as if no ring were stalled.
- R8: A host read-index write (`hostRdWe`) always loads that ring's shadow. If the ring is stalled and the new value differs from its write index plus one (mod `DEPTH`), the stall is low on the next cycle and the write index has advanced by one.
- R9: A host read-index write to a stalled ring whose value equals the write index plus one (mod `DEPTH`) frees no slot, and the ring stays stalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| segReq | input | 1 | Segmentation producer request |
| segRing | input | RING_W | Ring targeted by the segmentation request |
| segData | input | DATA_W | Segmentation status payload |
| segAck | output | 1 | Segmentation request accepted this cycle |
| rasReq | input | 1 | Reassembly producer request |
| rasRing | input | RING_W | Ring targeted by the reassembly request |
| rasData | input | DATA_W | Reassembly status payload |
| rasAck | output | 1 | Reassembly request accepted this cycle |
| hostRdWe | input | 1 | Host read-index update strobe |
| hostRdRing | input | RING_W | Ring whose read index is updated |
| hostRdIdx | input | IDX_W | New host read index |
| memWe | output | 1 | Memory write strobe |
| memAddr | output | ADDR_W | Memory write address |
| memData | output | DATA_W+1 | Entry: overflow bit on top of the payload |
| memOvfl | output | 1 | Current write is an overflow entry |
| ringStall | output | NUM_RINGS | Per-ring stall, one bit per ring |

## Verification
The bench builds the block with its defaults: four rings, a depth of 16 and eight-byte entries. A depth of 16 lets one ring be filled until it overflows in a few dozen cycles, and lets the index wrap many times during the run. A long stretch of pseudo-random traffic drives both producers and host updates against an arithmetic model. That traffic reaches stalls on several rings at once, arbitration collisions on the same ring and on different rings, and host updates that land on stalled rings both with and without freeing a slot.

// File: rtl/srg_pkg.sv
package srg_pkg;

  // Strobes from the control to the datapath for one grant cycle.
  typedef struct packed {
    logic post;     // a request was granted this cycle
    logic pickRas;  // payload comes from the reassembly producer
    logic ovfl;     // this entry takes the last free slot
  } srgStrobe_t;

endpackage

// File: rtl/srg_ctrl.sv
module srg_ctrl
  import srg_pkg::*;
#(
  parameter int NUM_RINGS = 4,
  parameter int DEPTH     = 16,
  parameter int RING_W    = 2,
  parameter int IDX_W     = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  segReq,
  input  logic [RING_W-1:0]     segRing,
  input  logic                  rasReq,
  input  logic [RING_W-1:0]     rasRing,
  input  logic                  hostRdWe,
  input  logic [RING_W-1:0]     hostRdRing,
  input  logic [IDX_W-1:0]      hostRdIdx,
  output logic                  segAck,
  output logic                  rasAck,
  output srgStrobe_t            strobe,
  output logic [RING_W-1:0]     grantRing,
  output logic [IDX_W-1:0]      grantIdx,
  output logic [NUM_RINGS-1:0]  ringStall
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

  // Next ring position with wrap at the configured depth.
  function automatic logic [IDX_W-1:0] bump(input logic [IDX_W-1:0] v);
    return (v == LAST_IDX) ? '0 : v + 1'b1;
  endfunction

  logic [NUM_RINGS*IDX_W-1:0] wrFlat;
  logic [NUM_RINGS*IDX_W-1:0] rdFlat;
  logic [NUM_RINGS-1:0]       stallQ;

  logic              segOk;
  logic              rasOk;
  logic [IDX_W-1:0]  gShadow;
  logic [IDX_W-1:0]  gNext;

  // Fixed-priority arbitration: segmentation wins over reassembly.
  always_comb begin
    segOk     = segReq && !stallQ[segRing];
    rasOk     = rasReq && !stallQ[rasRing] && !segOk;
    grantRing = rasOk ? rasRing : segRing;
    grantIdx  = wrFlat[grantRing*IDX_W +: IDX_W];
    gShadow   = rdFlat[grantRing*IDX_W +: IDX_W];
    gNext     = bump(grantIdx);
    strobe.post    = segOk || rasOk;
    strobe.pickRas = rasOk;
    strobe.ovfl    = (gNext == gShadow);
  end

  assign segAck    = segOk;
  assign rasAck    = rasOk;
  assign ringStall = stallQ;

  // Per-ring state: write index, host read shadow, stall flag.
  for (genvar r = 0; r < NUM_RINGS; r++) begin : ringSlot
    logic [IDX_W-1:0] wrQ;
    logic [IDX_W-1:0] rdQ;
    logic             stQ;
    logic             postHit;
    logic             hostHit;
    logic             frees;

    assign postHit = strobe.post && (grantRing == RING_W'(r));
    assign hostHit = hostRdWe && (hostRdRing == RING_W'(r));
    assign frees   = stQ && (hostRdIdx != bump(wrQ));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        wrQ <= '0;
        rdQ <= '0;
        stQ <= 1'b0;
      end else begin
        // A stalled ring is never granted, so these two branches never meet.
        if (postHit) begin
          if (strobe.ovfl) stQ <= 1'b1;
          else             wrQ <= bump(wrQ);
        end
        if (hostHit) begin
          rdQ <= hostRdIdx;
          if (frees) begin
            stQ <= 1'b0;
            wrQ <= bump(wrQ);
          end
        end
      end
    end

    assign wrFlat[r*IDX_W +: IDX_W] = wrQ;
    assign rdFlat[r*IDX_W +: IDX_W] = rdQ;
    assign stallQ[r]                = stQ;
  end

endmodule

// File: rtl/srg_datapath.sv
module srg_datapath
  import srg_pkg::*;
#(
  parameter int NUM_RINGS   = 4,
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 32,
  parameter int ENTRY_BYTES = 8,
  parameter int RING_W      = 2,
  parameter int IDX_W       = 4,
  parameter logic [ADDR_W-1:0] BASE_ORIGIN = 32'h0001_0000,
  parameter logic [ADDR_W-1:0] BASE_STRIDE = 32'h0000_1000
) (
  input  logic               clk,
  input  logic               rstN,
  input  srgStrobe_t         strobe,
  input  logic [RING_W-1:0]  grantRing,
  input  logic [IDX_W-1:0]   grantIdx,
  input  logic [DATA_W-1:0]  segData,
  input  logic [DATA_W-1:0]  rasData,
  output logic               memWe,
  output logic [ADDR_W-1:0]  memAddr,
  output logic [DATA_W:0]    memData,
  output logic               memOvfl
);

  localparam bit ENTRY_POW2  = (ENTRY_BYTES & (ENTRY_BYTES - 1)) == 0;
  localparam int ENTRY_SHIFT = $clog2(ENTRY_BYTES);

  logic [ADDR_W-1:0] ringBase;
  logic [ADDR_W-1:0] slotOffs;
  logic [DATA_W-1:0] payload;

  assign ringBase = BASE_ORIGIN + ADDR_W'(grantRing) * BASE_STRIDE;

  // Entry scaling: a shift for power-of-two sizes, a multiply otherwise.
  if (ENTRY_POW2) begin : gScaleShift
    assign slotOffs = ADDR_W'(grantIdx) << ENTRY_SHIFT;
  end else begin : gScaleMul
    assign slotOffs = ADDR_W'(grantIdx) * ADDR_W'(ENTRY_BYTES);
  end

  assign payload = strobe.pickRas ? rasData : segData;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      memWe   <= 1'b0;
      memOvfl <= 1'b0;
      memAddr <= '0;
      memData <= '0;
    end else begin
      memWe   <= strobe.post;
      memOvfl <= strobe.post && strobe.ovfl;
      if (strobe.post) begin
        memAddr <= ringBase + slotOffs;
        memData <= {strobe.ovfl, payload};
      end
    end
  end

endmodule

// File: rtl/status_ring_guard.sv
module status_ring_guard
  import srg_pkg::*;
#(
  parameter int NUM_RINGS   = 4,
  parameter int DEPTH       = 16,
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 32,
  parameter int ENTRY_BYTES = 8,
  parameter logic [ADDR_W-1:0] BASE_ORIGIN = 32'h0001_0000,
  parameter logic [ADDR_W-1:0] BASE_STRIDE = 32'h0000_1000,
  localparam int RING_W = (NUM_RINGS > 1) ? $clog2(NUM_RINGS) : 1,
  localparam int IDX_W  = $clog2(DEPTH)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  segReq,
  input  logic [RING_W-1:0]     segRing,
  input  logic [DATA_W-1:0]     segData,
  output logic                  segAck,
  input  logic                  rasReq,
  input  logic [RING_W-1:0]     rasRing,
  input  logic [DATA_W-1:0]     rasData,
  output logic                  rasAck,
  input  logic                  hostRdWe,
  input  logic [RING_W-1:0]     hostRdRing,
  input  logic [IDX_W-1:0]      hostRdIdx,
  output logic                  memWe,
  output logic [ADDR_W-1:0]     memAddr,
  output logic [DATA_W:0]       memData,
  output logic                  memOvfl,
  output logic [NUM_RINGS-1:0]  ringStall
);

  srgStrobe_t        strobe;
  logic [RING_W-1:0] grantRing;
  logic [IDX_W-1:0]  grantIdx;

  srg_ctrl #(
    .NUM_RINGS(NUM_RINGS), .DEPTH(DEPTH), .RING_W(RING_W), .IDX_W(IDX_W)
  ) uCtrl (
    .clk(clk), .rstN(rstN),
    .segReq(segReq), .segRing(segRing),
    .rasReq(rasReq), .rasRing(rasRing),
    .hostRdWe(hostRdWe), .hostRdRing(hostRdRing), .hostRdIdx(hostRdIdx),
    .segAck(segAck), .rasAck(rasAck),
    .strobe(strobe), .grantRing(grantRing), .grantIdx(grantIdx),
    .ringStall(ringStall)
  );

  srg_datapath #(
    .NUM_RINGS(NUM_RINGS), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
    .ENTRY_BYTES(ENTRY_BYTES), .RING_W(RING_W), .IDX_W(IDX_W),
    .BASE_ORIGIN(BASE_ORIGIN), .BASE_STRIDE(BASE_STRIDE)
  ) uPath (
    .clk(clk), .rstN(rstN),
    .strobe(strobe), .grantRing(grantRing), .grantIdx(grantIdx),
    .segData(segData), .rasData(rasData),
    .memWe(memWe), .memAddr(memAddr), .memData(memData), .memOvfl(memOvfl)
  );

endmodule

// File: rtl/srg_checker.sv
module srg_checker #(
  parameter int NUM_RINGS = 4,
  parameter int DATA_W    = 32,
  parameter int RING_W    = 2
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 segReq,
  input logic [RING_W-1:0]    segRing,
  input logic                 segAck,
  input logic                 rasReq,
  input logic [RING_W-1:0]    rasRing,
  input logic                 rasAck,
  input logic                 hostRdWe,
  input logic [RING_W-1:0]    hostRdRing,
  input logic                 memWe,
  input logic [DATA_W:0]      memData,
  input logic                 memOvfl,
  input logic [NUM_RINGS-1:0] ringStall
);

  logic [RING_W-1:0] ackRing;
  assign ackRing = segAck ? segRing : rasRing;

  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rstN)
    !(segAck && rasAck)) else $error("AST_ONE_GRANT"); // R2

  AST_SEG_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    (segReq && !ringStall[segRing]) |-> segAck) else $error("AST_SEG_FIRST"); // R2

  AST_SEG_REFUSED: assert property (@(posedge clk) disable iff (!rstN)
    segAck |-> !ringStall[segRing]) else $error("AST_SEG_REFUSED"); // R7

  AST_RAS_REFUSED: assert property (@(posedge clk) disable iff (!rstN)
    rasAck |-> !ringStall[rasRing]) else $error("AST_RAS_REFUSED"); // R7

  AST_POST_NEXT: assert property (@(posedge clk) disable iff (!rstN)
    (segAck || rasAck) |=> memWe) else $error("AST_POST_NEXT"); // R3

  AST_NO_SPURIOUS_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    !(segAck || rasAck) |=> !memWe) else $error("AST_NO_SPURIOUS_WRITE"); // R3

  AST_FLAG_BIT: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> (memData[DATA_W] == memOvfl)) else $error("AST_FLAG_BIT"); // R4

  AST_OVFL_STALLS: assert property (@(posedge clk) disable iff (!rstN)
    (memWe && memOvfl) |-> ringStall[$past(ackRing)]) else $error("AST_OVFL_STALLS"); // R5

  for (genvar r = 0; r < NUM_RINGS; r++) begin : perRing
    AST_STALL_RISE: assert property (@(posedge clk) disable iff (!rstN)
      $rose(ringStall[r]) |-> (memWe && memOvfl)) else $error("AST_STALL_RISE"); // R5

    AST_STALL_FALL: assert property (@(posedge clk) disable iff (!rstN)
      $fell(ringStall[r]) |-> ($past(hostRdWe) && ($past(hostRdRing) == RING_W'(r))))
      else $error("AST_STALL_FALL"); // R8
  end

endmodule

bind status_ring_guard srg_checker #(
  .NUM_RINGS(NUM_RINGS), .DATA_W(DATA_W), .RING_W(RING_W)
) uChk (
  .clk(clk), .rstN(rstN),
  .segReq(segReq), .segRing(segRing), .segAck(segAck),
  .rasReq(rasReq), .rasRing(rasRing), .rasAck(rasAck),
  .hostRdWe(hostRdWe), .hostRdRing(hostRdRing),
  .memWe(memWe), .memData(memData), .memOvfl(memOvfl),
  .ringStall(ringStall)
);

// File: tb/sim_status_ring_guard.sv
module sim_status_ring_guard;

  localparam int NR    = 4;
  localparam int DEPTH = 16;
  localparam int DW    = 32;
  localparam int AW    = 32;
  localparam int EB    = 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          segReq = 1'b0, rasReq = 1'b0, hostRdWe = 1'b0;
  logic [1:0]    segRing = '0, rasRing = '0, hostRdRing = '0;
  logic [DW-1:0] segData = '0, rasData = '0;
  logic [3:0]    hostRdIdx = '0;
  logic          segAck, rasAck, memWe, memOvfl;
  logic [AW-1:0] memAddr;
  logic [DW:0]   memData;
  logic [NR-1:0] ringStall;

  always #5 clk = ~clk;

  status_ring_guard #(
    .NUM_RINGS(NR), .DEPTH(DEPTH), .DATA_W(DW), .ADDR_W(AW), .ENTRY_BYTES(EB)
  ) u0 (
    .clk(clk), .rstN(rstN),
    .segReq(segReq), .segRing(segRing), .segData(segData), .segAck(segAck),
    .rasReq(rasReq), .rasRing(rasRing), .rasData(rasData), .rasAck(rasAck),
    .hostRdWe(hostRdWe), .hostRdRing(hostRdRing), .hostRdIdx(hostRdIdx),
    .memWe(memWe), .memAddr(memAddr), .memData(memData), .memOvfl(memOvfl),
    .ringStall(ringStall)
  );

  int  checks = 0;
  int  failures = 0;
  bit  done = 1'b0;
  int  mWr[NR];
  int  mRd[NR];
  bit  mSt[NR];
  bit  lastSegAck, lastRasAck, lastOvfl;
  logic [31:0] lfsr = 32'h1BAD_F00D;

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] rnd();
    lfsr = lfsr ^ (lfsr << 13);
    lfsr = lfsr ^ (lfsr >> 17);
    lfsr = lfsr ^ (lfsr << 5);
    return lfsr;
  endfunction

  function automatic logic [NR-1:0] stallVec();
    logic [NR-1:0] v;
    for (int i = 0; i < NR; i++) v[i] = mSt[i];
    return v;
  endfunction

  // One cycle: drive at the falling edge, check acks, then check the
  // registered outputs after the next rising edge against the model.
  task automatic step(input bit sR, input int sRg, input logic [31:0] sD,
                      input bit rR, input int rRg, input logic [31:0] rD,
                      input bit hW, input int hRg, input int hIdx);
    bit segOk, rasOk, post, ovf;
    bit oldSt[NR];
    int g, idx;
    longint expAddr, expData;
    segReq = sR; segRing = 2'(sRg); segData = sD;
    rasReq = rR; rasRing = 2'(rRg); rasData = rD;
    hostRdWe = hW; hostRdRing = 2'(hRg); hostRdIdx = 4'(hIdx);
    #1;
    segOk = sR && !mSt[sRg];
    rasOk = rR && !mSt[rRg] && !segOk;
    chk("R2 segAck", segAck, segOk);
    chk("R2/R7 rasAck", rasAck, rasOk);
    lastSegAck = segOk; lastRasAck = rasOk;
    post = segOk || rasOk;
    g = segOk ? sRg : rRg;
    idx = mWr[g];
    ovf = (((idx + 1) % DEPTH) == mRd[g]);
    expAddr = 64'h1_0000 + g * 64'h1000 + idx * EB;
    expData = {ovf, (segOk ? sD : rD)};
    for (int i = 0; i < NR; i++) oldSt[i] = mSt[i];
    if (post) begin
      if (ovf) mSt[g] = 1'b1;
      else     mWr[g] = (idx + 1) % DEPTH;
    end
    if (hW) begin
      if (oldSt[hRg] && (hIdx != (mWr[hRg] + 1) % DEPTH)) begin
        mSt[hRg] = 1'b0;
        mWr[hRg] = (mWr[hRg] + 1) % DEPTH;
      end
      mRd[hRg] = hIdx;
    end
    lastOvfl = post && ovf;
    @(posedge clk); #2;
    chk("R3 memWe", memWe, post);
    if (post) begin
      chk("R3/R6 memAddr", memAddr, expAddr);
      chk("R4 memData", memData, expData);
    end
    chk("R5 memOvfl", memOvfl, post && ovf);
    chk("R5/R7/R8/R9 ringStall", ringStall, stallVec());
    @(negedge clk);
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int ovflCount;
    bit sPend, rPend;
    int sRg, rRg;
    logic [31:0] sD, rD;
    for (int i = 0; i < NR; i++) begin mWr[i] = 0; mRd[i] = 0; mSt[i] = 0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1: reset state, no requests pending
    chk("R1 ringStall", ringStall, 0);
    chk("R1 memWe", memWe, 0);
    chk("R1 memOvfl", memOvfl, 0);
    chk("R1 segAck", segAck, 0);
    chk("R1 rasAck", rasAck, 0);
    idle();

    // R5/R6: fill ring 0 from the segmentation side; exactly one overflow
    ovflCount = 0;
    for (int k = 0; k < DEPTH; k++) begin
      step(1, 0, 32'hA000 + k, 0, 0, 0, 0, 0, 0);
      if (lastOvfl) ovflCount++;
    end
    chk("R5 single overflow entry", ovflCount, 1);
    chk("R5 ring0 stalled", ringStall[0], 1);
    chk("R7 other rings free", ringStall[3:1], 0);

    // R7: stalled ring refused, reassembly on ring 1 still served
    step(1, 0, 32'hBEEF, 1, 1, 32'hC001, 0, 0, 0);
    chk("R7 stalled seg refused", lastSegAck, 0);
    chk("R7 other ring served", lastRasAck, 1);

    // R2: collision on two free rings, loser held and then accepted
    step(1, 2, 32'hD002, 1, 3, 32'hE003, 0, 0, 0);
    chk("R2 seg wins", lastSegAck, 1);
    chk("R2 ras waits", lastRasAck, 0);
    step(0, 0, 0, 1, 3, 32'hE003, 0, 0, 0);
    chk("R2 held ras granted", lastRasAck, 1);

    // R9: host update that frees nothing keeps the stall
    step(0, 0, 0, 0, 0, 0, 1, 0, 0);
    chk("R9 still stalled", ringStall[0], 1);
    step(1, 0, 32'h1111, 0, 0, 0, 0, 0, 0);
    chk("R9 still refused", lastSegAck, 0);

    // R8: host frees slots, stall drops next cycle, index wraps to 0
    step(0, 0, 0, 0, 0, 0, 1, 0, 5);
    chk("R8 stall cleared", ringStall[0], 0);
    step(1, 0, 32'h2222, 0, 0, 0, 0, 0, 0);
    chk("R8/R6 index past overflow", memAddr, 32'h1_0000);
    // refill against shadow 5: indices 1..3 normal, 4 overflows
    ovflCount = 0;
    for (int k = 0; k < 4; k++) begin
      step(0, 0, 0, 1, 0, 32'h3300 + k, 0, 0, 0);
      if (lastOvfl) ovflCount++;
    end
    chk("R5 overflow one slot early", ovflCount, 1);
    chk("R5 overflow address", memAddr, 32'h1_0000 + 4 * EB);
    step(0, 0, 0, 0, 0, 0, 1, 0, 4);

    // Mixed traffic sweep with held requests and random host updates
    sPend = 0; rPend = 0; sRg = 0; rRg = 0; sD = 0; rD = 0;
    for (int c = 0; c < 6000; c++) begin
      logic [31:0] v;
      bit hW;
      int hRg, hIdx;
      v = rnd();
      if (!sPend && v[1:0] != 0) begin sPend = 1; sRg = int'(v[5:4]); sD = rnd(); end
      if (!rPend && v[3:2] != 0) begin rPend = 1; rRg = int'(v[7:6]); rD = rnd(); end
      hW = (v[10:8] == 0);
      hRg = int'(v[12:11]);
      hIdx = v[13] ? mWr[hRg] : int'(v[19:16]);
      step(sPend, sRg, sD, rPend, rRg, rD, hW, hRg, hIdx);
      if (lastSegAck) sPend = 0;
      if (lastRasAck) rPend = 0;
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule